// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a bank of processor configuration registers on a byte-wide I/O bus. Software reaches the bank through two I/O addresses. A write to the index address picks a register. The next access to the data address then reads or writes that register. Each data access uses up the selection, so every data transfer needs a fresh index write before it.

The block decides in the same cycle whether the bank serves an access or whether it goes out as an external I/O cycle. Two bits of the third control register steer this decision:

- The map-enable bit adds a second group of registers to the bank.
- The sticky lock bit stops writes to the base control group.

Two read-only identifier registers are always present. A read that the bank does not serve returns FFh on the read-data port. Every register value is brought out on a flat bus for the rest of the chip.

Top module: `cfg_index_port`

## Requirements
- R1: A write to address IDX_PORT (default 22h) is claimed on-chip (`ext_cycle`=0) and stores the index. The next access to DATA_PORT (default 23h) reads or writes the register at that index. Read data appears on `io_rdata` in the same cycle as `io_rd`.
- R2: Any access to DATA_PORT clears the index selection. A DATA_PORT access made without a fresh index write is forwarded (`ext_cycle`=1). Accesses to other addresses leave the selection unchanged.
- R3: While map-enable is 0, only indexes C1h, C2h, C3h, CDh, CEh, CFh, FEh and FFh are claimed. Every other index is forwarded.
- R4: Map-enable is bit 4 of the register at C3h. While it is 1, indexes E8h, EBh, 20h and B0h–B3h are also claimed, read and written.
- R5: The lock bit is bit 0 of the register at C3h. While it is 1, a claimed write to C1h, C2h, C3h, CDh, CEh or CFh leaves the register unchanged. Writes to E8h, EBh, 20h and B0h–B3h still take effect.
- R6: Once the lock bit is 1, only reset clears it.
- R7: Index FEh reads {4h, DEV_REV}. Index FFh reads DEV_ID. Writes to these two indexes change nothing.
- R8: Synchronous active-low reset sets E8h to 85h and 20h to 07h. All other registers reset to 00h, and the index selection is cleared.
- R9: A DATA_PORT access that is not claimed asserts `ext_cycle` in the same cycle and changes no register. If it is a read, `io_rdata` is FFh.
- R10: Any access to an address other than IDX_PORT or DATA_PORT asserts `ext_cycle` in the same cycle. This includes a read of IDX_PORT. The read data for such an access is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| ext_cycle | output | 1 | Access is forwarded to the external bus |
| map_en | output | 1 | Current map-enable bit |
| lock | output | 1 | Current lock bit |
| cfg_bank | output | 104 | Register values in 8-bit slots. Slot k is at [8k+7:8k]. Slot order: C1, C2, C3, CD, CE, CF, E8, EB, 20, B0, B1, B2, B3 |

## Verification
The bench keeps the default port addresses, 22h and 23h. It overrides DEV_REV to Ah and DEV_ID to 5Ch, so the identifier reads are checked against values different from the defaults. This shows the reads follow the parameters and are not fixed constants. The stimulus table moves the bank through three states in turn: map off, map on, then locked with map on. It covers gated and ungated registers in each state, and an unimplemented index inside the C0h–CFh window. A reset in the middle of the run, followed by an access to another address placed between an index write and a data read, brings the stickiness of the lock and the persistence of the selection within reach.

// File: rtl/cfg_idx_pkg.sv
// Package: shared slot description for the indexed configuration bank.
// Assumes a byte-wide register file. The slot order is fixed, because the
// flat output bus and the control-bit positions depend on it.
package cfg_idx_pkg;

    localparam int NSLOT  = 13;
    localparam int CTL_SLOT = 2;     // slot that holds map-enable and lock
    localparam int MAP_BIT  = 4;
    localparam int LOCK_BIT = 0;
    localparam logic [7:0] ID0_IDX = 8'hFE;
    localparam logic [7:0] ID1_IDX = 8'hFF;

    typedef struct packed {
        logic [7:0] idx;     // index number
        logic [7:0] rstv;    // reset value
        logic       gated;   // reachable only with map-enable
        logic       locked;  // writes blocked by lock bit
    } slot_t;

    localparam slot_t SLOTS [NSLOT] = '{
        '{8'hC1, 8'h00, 1'b0, 1'b1},
        '{8'hC2, 8'h00, 1'b0, 1'b1},
        '{8'hC3, 8'h00, 1'b0, 1'b1},
        '{8'hCD, 8'h00, 1'b0, 1'b1},
        '{8'hCE, 8'h00, 1'b0, 1'b1},
        '{8'hCF, 8'h00, 1'b0, 1'b1},
        '{8'hE8, 8'h85, 1'b1, 1'b0},
        '{8'hEB, 8'h00, 1'b1, 1'b0},
        '{8'h20, 8'h07, 1'b1, 1'b0},
        '{8'hB0, 8'h00, 1'b1, 1'b0},
        '{8'hB1, 8'h00, 1'b1, 1'b0},
        '{8'hB2, 8'h00, 1'b1, 1'b0},
        '{8'hB3, 8'h00, 1'b1, 1'b0}
    };

endpackage

// File: rtl/cfg_idx_tracker.sv
// Module: holds the selected index and a one-shot valid flag.
// An index write sets the flag. Any data-port access clears it.
// Assumes the set and clear strobes never come in the same cycle.
module cfg_idx_tracker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       clr_i,
    input  logic [7:0] idx_i,
    output logic [7:0] idx_o,
    output logic       vld_o
);

    // Capture the index and track whether it is still unused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= 8'h00;
            vld_o <= 1'b0;
        end else if (set_i) begin
            idx_o <= idx_i;
            vld_o <= 1'b1;
        end else if (clr_i) begin
            vld_o <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_idx_decode.sv
// Module: turns an index into a one-hot slot hit and identifier hits.
// Gated slots hit only while map-enable is set. Purely combinational.
module cfg_idx_decode
    import cfg_idx_pkg::*;
(
    input  logic [7:0]       idx_i,
    input  logic             map_en_i,
    output logic [NSLOT-1:0] hit_o,
    output logic             id0_o,
    output logic             id1_o,
    output logic             claim_o
);

    for (genvar k = 0; k < NSLOT; k++) begin : g_hit
        // Match one slot index, qualified by the map-enable rule.
        always_comb hit_o[k] = (idx_i == SLOTS[k].idx) &&
                               (!SLOTS[k].gated || map_en_i);
    end

    // Identify the read-only identifier indexes and the overall claim.
    always_comb begin
        id0_o   = (idx_i == ID0_IDX);
        id1_o   = (idx_i == ID1_IDX);
        claim_o = (|hit_o) || id0_o || id1_o;
    end

endmodule

// File: rtl/cfg_idx_regfile.sv
// Module: storage for the configuration slots, the lock write-protect rule
// and the read multiplexer. Assumes hit_i is one-hot or zero.
module cfg_idx_regfile
    import cfg_idx_pkg::*;
#(
    parameter logic [3:0] DEV_REV = 4'h1,
    parameter logic [7:0] DEV_ID  = 8'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [7:0]       wdata_i,
    input  logic [NSLOT-1:0] hit_i,
    input  logic             id0_i,
    input  logic             id1_i,
    output logic [7:0]       rdata_o,
    output logic [NSLOT*8-1:0] bank_o,
    output logic             map_en_o,
    output logic             lock_o
);

    logic [7:0] q [NSLOT];

    assign map_en_o = q[CTL_SLOT][MAP_BIT];
    assign lock_o   = q[CTL_SLOT][LOCK_BIT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        // Update one slot, honouring the lock for protected slots.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[k] <= SLOTS[k].rstv;
            else if (we_i && hit_i[k] && !(SLOTS[k].locked && lock_o))
                q[k] <= wdata_i;
        end
        assign bank_o[k*8 +: 8] = q[k];
    end

    // Select the read value from the hit slot or an identifier.
    always_comb begin
        rdata_o = 8'h00;
        for (int k = 0; k < NSLOT; k++)
            if (hit_i[k]) rdata_o = rdata_o | q[k];
        if (id0_i) rdata_o = {4'h4, DEV_REV};
        if (id1_i) rdata_o = DEV_ID;
    end

endmodule

// File: rtl/cfg_index_port.sv
// Module: top of the indexed configuration port. Decodes the I/O address,
// claims on-chip accesses and forwards the rest as external cycles.
// Assumes io_rd and io_wr are never both high and each lasts one cycle.
module cfg_index_port
    import cfg_idx_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h22,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h23,
    parameter logic [3:0]      DEV_REV   = 4'h1,
    parameter logic [7:0]      DEV_ID    = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              ext_cycle,
    output logic              map_en,
    output logic              lock,
    output logic [NSLOT*8-1:0] cfg_bank
);

    logic             acc, at_idx, at_dat, idx_wr, dat_acc, claim_dat;
    logic [7:0]       idx_q, bank_rd;
    logic             idx_vld, dec_claim, id0, id1;
    logic [NSLOT-1:0] hit;

    // Classify the current request by address and strobe.
    always_comb begin
        acc       = io_rd || io_wr;
        at_idx    = (io_addr == IDX_PORT);
        at_dat    = (io_addr == DATA_PORT);
        idx_wr    = at_idx && io_wr;
        dat_acc   = at_dat && acc;
        claim_dat = dat_acc && idx_vld && dec_claim;
        ext_cycle = acc && !(idx_wr || claim_dat);
        io_rdata  = (io_rd && claim_dat) ? bank_rd : 8'hFF;
    end

    cfg_idx_tracker u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (idx_wr),
        .clr_i (dat_acc),
        .idx_i (io_wdata),
        .idx_o (idx_q),
        .vld_o (idx_vld)
    );

    cfg_idx_decode u_dec (
        .idx_i    (idx_q),
        .map_en_i (map_en),
        .hit_o    (hit),
        .id0_o    (id0),
        .id1_o    (id1),
        .claim_o  (dec_claim)
    );

    cfg_idx_regfile #(.DEV_REV(DEV_REV), .DEV_ID(DEV_ID)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (claim_dat && io_wr),
        .wdata_i  (io_wdata),
        .hit_i    (hit),
        .id0_i    (id0),
        .id1_i    (id1),
        .rdata_o  (bank_rd),
        .bank_o   (cfg_bank),
        .map_en_o (map_en),
        .lock_o   (lock)
    );

endmodule

// File: rtl/cfg_index_port_chk.sv
// Module: assertion checker bound to cfg_index_port. Observes ports and the
// index tracker state; drives nothing.
module cfg_index_port_chk #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h22,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic              ext_cycle,
    input logic              map_en,
    input logic              lock,
    input logic              idx_vld,
    input logic [7:0]        idx_q,
    input logic [7:0]        c1_val
);

    logic acc_dat, acc_oth;
    assign acc_dat = (io_rd || io_wr) && io_addr == DATA_PORT;
    assign acc_oth = (io_rd || io_wr) && io_addr != DATA_PORT && io_addr != IDX_PORT;

    p_stale_data_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_dat && !idx_vld |-> ext_cycle);

    p_index_consumed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_dat |=> !idx_vld);

    p_gated_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_dat && idx_vld && !map_en && idx_q == 8'hE8 |-> ext_cycle);

    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock && io_wr && acc_dat && idx_q == 8'hC1 |=> $stable(c1_val));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    p_ext_read_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cycle && io_rd |-> io_rdata == 8'hFF);

    p_other_addr_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_oth |-> ext_cycle);

endmodule

bind cfg_index_port cfg_index_port_chk #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .ext_cycle(ext_cycle), .map_en(map_en), .lock(lock),
    .idx_vld(idx_vld), .idx_q(idx_q), .c1_val(cfg_bank[7:0])
);

// File: tb/cfg_index_port_tb.sv
// Bench: vector table walk, then directed reset and selection tests.
module cfg_index_port_tb;

    localparam int NS = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   io_addr = '0;
    logic          io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic          ext_cycle, map_en, lock;
    logic [NS*8-1:0] cfg_bank;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cfg_index_port #(.DEV_REV(4'hA), .DEV_ID(8'h5C)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ext_cycle(ext_cycle), .map_en(map_en), .lock(lock), .cfg_bank(cfg_bank)
    );

    typedef struct packed {
        logic [15:0] a;
        logic        w;
        logic        r;
        logic [7:0]  d;
        logic        ext;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        '{16'h23,0,1,8'h00,1,8'hFF,4'd2},  // R2 no index yet
        '{16'h22,1,0,8'hC1,0,8'hFF,4'd1},  // R1
        '{16'h23,1,0,8'h5A,0,8'hFF,4'd1},
        '{16'h22,1,0,8'hC1,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h5A,4'd1},  // R1 read back
        '{16'h23,0,1,8'h00,1,8'hFF,4'd2},  // R2 consumed
        '{16'h22,1,0,8'hE8,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,1,8'hFF,4'd3},  // R3 gated hidden
        '{16'h22,1,0,8'hC5,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,1,8'hFF,4'd9},  // R9 unimplemented
        '{16'h22,1,0,8'hFE,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h4A,4'd7},  // R7 id0
        '{16'h22,1,0,8'hFF,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h00,0,8'hFF,4'd7},
        '{16'h22,1,0,8'hFF,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h5C,4'd7},  // R7 id1 unchanged
        '{16'h60,0,1,8'h00,1,8'hFF,4'd10}, // R10
        '{16'h80,1,0,8'h33,1,8'hFF,4'd10},
        '{16'h22,0,1,8'h00,1,8'hFF,4'd10},
        '{16'h22,1,0,8'hC3,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h10,0,8'hFF,4'd4},  // R4 map on
        '{16'h22,1,0,8'hE8,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h85,4'd8},  // R8 E8 default
        '{16'h22,1,0,8'h20,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h07,4'd8},  // R8 20 default
        '{16'h22,1,0,8'hB2,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h77,0,8'hFF,4'd4},
        '{16'h22,1,0,8'hB2,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h77,4'd4},  // R4
        '{16'h22,1,0,8'hC3,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h11,0,8'hFF,4'd5},  // lock on
        '{16'h22,1,0,8'hC2,0,8'hFF,4'd1},
        '{16'h23,1,0,8'hAA,0,8'hFF,4'd5},
        '{16'h22,1,0,8'hC2,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h00,4'd5},  // R5 blocked
        '{16'h22,1,0,8'hC3,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h00,0,8'hFF,4'd6},
        '{16'h22,1,0,8'hC3,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h11,4'd6},  // R6 still locked
        '{16'h22,1,0,8'hEB,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h3C,0,8'hFF,4'd5},
        '{16'h22,1,0,8'hEB,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h3C,4'd5},  // R5 ungated writable
        '{16'h22,1,0,8'hC1,0,8'hFF,4'd1},
        '{16'h23,1,0,8'h00,0,8'hFF,4'd5},
        '{16'h22,1,0,8'hC1,0,8'hFF,4'd1},
        '{16'h23,0,1,8'h00,0,8'h5A,4'd5}   // R5 C1 kept
    };

    task automatic chk(input bit ok, input int req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_io(input vec_t v);
        @(negedge clk);
        io_addr = v.a; io_wr = v.w; io_rd = v.r; io_wdata = v.d;
        #5;
        chk(ext_cycle === v.ext, int'(v.req), {7'b0, ext_cycle}, {7'b0, v.ext});
        if (v.r) chk(io_rdata === v.exp, int'(v.req), io_rdata, v.exp);
        @(posedge clk); #1;
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    // R8: check bank, map_en and lock against reset values
    task automatic chk_reset();
        logic [7:0] rv [NS] = '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,
                               8'h85,8'h00,8'h07,8'h00,8'h00,8'h00,8'h00};
        for (int k = 0; k < NS; k++)
            chk(cfg_bank[k*8 +: 8] === rv[k], 8, cfg_bank[k*8 +: 8], rv[k]);
        chk({map_en, lock} === 2'b00, 8, {6'b0, map_en, lock}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk_reset();
        for (int i = 0; i < NV; i++) do_io(VEC[i]);
        @(negedge clk);
        chk(cfg_bank[7:0] === 8'h5A, 5, cfg_bank[7:0], 8'h5A);       // R5
        chk(lock === 1'b1, 6, {7'b0, lock}, 8'h01);                  // R6
        // R6: only reset clears the lock
        rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(lock === 1'b0, 6, {7'b0, lock}, 8'h00);
        chk_reset();
        // R2: other-address access does not consume the selection
        do_io('{16'h22,1,0,8'hC1,0,8'hFF,4'd1});
        do_io('{16'h60,0,1,8'h00,1,8'hFF,4'd10});
        do_io('{16'h23,0,1,8'h00,0,8'h00,4'd2});
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                chk(1'b0, 0, 8'h00, 8'h01);  // watchdog expired
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule